// File: doc/BRIEF.md
# LPC Memory-Cycle Target

This block is the target end of a Low Pin Count bus placed in front of a flash-style storage array. It samples a 4-bit multiplexed address/data bus, a frame strobe and an active-low chip enable on every rising clock edge. When it sees a valid start followed by a memory read or memory write cycle type, it gathers the 32-bit address. It claims the cycle only if the upper address byte is a legal prefix and the device-select field matches a strap input. It then runs the rest of the bus cycle: host turnaround, sync, data and the final hand-back of the bus.

The storage side is a plain request/ready port. While the block waits in its sync phase it holds a request together with a word address, a space flag (memory or register), a write-enable and the write byte. The storage raises ready when the access is done, and on a read it presents the byte on the read-data input. A mode input held high parks the block for the parallel programming mode, in which it neither drives the bus nor requests storage. If the host pulls the frame strobe low in the middle of a cycle, the block drops that cycle at once and treats the strobe as the start of a new frame.

Top module: `lpc_mem_target`

## Requirements
- R1: The start nibble is the last bus value sampled while the frame strobe is low. It is evaluated on the first clock the strobe is sampled high again, and only the value 0000 starts a cycle. The host may hold the strobe low for several clocks and change the nibble in that time.
- R2: A cycle is accepted only if chip enable was sampled low on the clock edge before the last frame-low clock. Otherwise the block never drives the bus and never raises a request.
- R3: The nibble sampled on the clock where the frame strobe releases is the cycle type: 0100 selects memory read and 0110 selects memory write. Any other type is ignored.
- R4: Eight address nibbles follow the cycle type, most significant first. The storage address is A[ADDR_W-1:0] (A18..A0 by default), and the space flag is A23 (1 = memory, 0 = register).
- R5: The cycle is claimed only when A31..A24 are all ones or all zeros and A22..A19 equal the device-ID strap. An unclaimed cycle leaves the bus undriven and raises no request.
- R6: On a write, two data nibbles follow the address directly, low nibble first. After two host turnaround clocks the request is raised with write-enable 1 and the assembled byte.
- R7: On a read, the two clocks after the address are host turnaround with the bus undriven. Then the request is raised with write-enable 0.
- R8: While the request is pending the block drives 0101 (wait) for at least one clock. On the clock after ready is sampled high it drives 0000 (ready) and drops the request.
- R9: On a read, the byte captured when ready was sampled is driven on the two clocks after 0000, low nibble first.
- R10: Every claimed cycle ends with the block driving 1111 for one clock and releasing the bus on the next.
- R11: A frame strobe sampled low during any phase aborts the cycle. On the next clock the bus is released, the request is low, and that low strobe counts as a new start.
- R12: With the programming-mode input high, the block stays idle: it never drives the bus and never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pp_mode_i | input | 1 | High parks the block (parallel programming mode) |
| ce_n_i | input | 1 | Active-low chip enable |
| frame_n_i | input | 1 | Active-low frame strobe |
| lad_i | input | 4 | Bus nibble as seen at the pad |
| lad_o | output | 4 | Nibble driven by the block |
| lad_oe_o | output | 1 | Output enable for lad_o |
| dev_id_i | input | ID_W | Device-select strap |
| mem_req_o | output | 1 | Storage access request |
| mem_we_o | output | 1 | 1 = write access |
| mem_space_o | output | 1 | 1 = memory space, 0 = register space |
| mem_addr_o | output | ADDR_W | Storage address |
| mem_wdata_o | output | DATA_W | Write byte |
| mem_rdata_i | input | DATA_W | Read byte from storage |
| mem_ready_i | input | 1 | Storage completion flag |

## Verification
Abort handling and sync completion can fall on the same clock: the host pulls the frame strobe low on the very edge where the storage raises ready. The bench provokes this by asserting ready and dropping the strobe together during the sync wait. The abort must win. On the next clock the bus is released, no 0000 ready nibble appears, and the request is low. A fresh read that reuses that strobe as its start must then complete normally.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

   localparam logic [3:0] NIB_START = 4'b0000;
   localparam logic [3:0] NIB_MRD   = 4'b0100;
   localparam logic [3:0] NIB_MWR   = 4'b0110;
   localparam logic [3:0] NIB_WAIT  = 4'b0101;
   localparam logic [3:0] NIB_RDY   = 4'b0000;
   localparam logic [3:0] NIB_TAR   = 4'b1111;
   localparam int         ADDR_NIB  = 8;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_ADDR,
      PH_WDATA,
      PH_HTAR,
      PH_SYNC_W,
      PH_SYNC_R,
      PH_RDATA,
      PH_TDRV,
      PH_TREL
   } phase_t;

endpackage

// File: rtl/lpc_tgt_start.sv
module lpc_tgt_start
   import lpc_tgt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       frame_n_i,
   input  logic       ce_n_i,
   input  logic [3:0] lad_i,
   output logic       framing_o,
   output logic       launch_o
);

   logic       ce_q;
   logic       in_frame_q;
   logic       qual_q;
   logic [3:0] start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_q       <= 1'b1;
         in_frame_q <= 1'b0;
         qual_q     <= 1'b0;
         start_q    <= NIB_TAR;
      end else begin
         ce_q <= ce_n_i;
         if (!en) begin
            in_frame_q <= 1'b0;
         end else if (!frame_n_i) begin
            in_frame_q <= 1'b1;
            start_q    <= lad_i;
            qual_q     <= ~ce_q;
         end else begin
            in_frame_q <= 1'b0;
         end
      end
   end

   assign framing_o = en & ~frame_n_i;
   assign launch_o  = en & frame_n_i & in_frame_q & qual_q & (start_q == NIB_START);

   // R1: a launch is only seen right after a frame-low sample
   a_r1_launch_after_frame : assert property (@(posedge clk) disable iff (!rst_n)
      launch_o |-> !$past(frame_n_i));

   // R2: chip enable was low on the edge before the start clock
   a_r2_ce_before_start : assert property (@(posedge clk) disable iff (!rst_n)
      launch_o |-> !$past(ce_n_i, 2));

endmodule

// File: rtl/lpc_tgt_addr.sv
module lpc_tgt_addr
   import lpc_tgt_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int ID_W     = 4,
   parameter int ID_LSB   = 19,
   parameter bit CHECK_ID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [3:0]        lad_i,
   input  logic [ID_W-1:0]   dev_id_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              space_o,
   output logic              hit_o
);

   localparam int SH_W = 4 * (ADDR_NIB - 1);

   logic [SH_W-1:0] sh_q;
   logic [31:0]     full;
   logic            prefix_ok;
   logic            id_ok;

   initial begin
      assert (ID_LSB + ID_W <= 23) else $fatal(1, "device-ID field overlaps space bit");
      assert (ADDR_W <= ID_LSB)    else $fatal(1, "address overlaps device-ID field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else if (shift_en) sh_q <= {sh_q[SH_W-5:0], lad_i};
   end

   assign full      = {sh_q, lad_i};
   assign prefix_ok = (&full[31:24]) | ~(|full[31:24]);
   assign addr_o    = full[ADDR_W-1:0];
   assign space_o   = full[23];

   generate
      if (CHECK_ID) begin : g_id_chk
         assign id_ok = (full[ID_LSB +: ID_W] == dev_id_i);
      end else begin : g_id_any
         assign id_ok = 1'b1;
      end
   endgenerate

   assign hit_o = prefix_ok & id_ok;

endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
   import lpc_tgt_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              framing,
   input  logic              launch,
   input  logic [3:0]        lad_i,
   input  logic              hit,
   input  logic              space,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              mem_ready_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              addr_shift,
   output logic [3:0]        lad_o,
   output logic              lad_oe_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic              mem_space_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);

   localparam int DATA_NIB = DATA_W / 4;
   localparam int CNT_MAX  = (DATA_NIB > ADDR_NIB) ? DATA_NIB : ADDR_NIB;
   localparam int CNT_W    = $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_NIB - 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_NIB - 1);
   localparam logic [CNT_W-1:0] LAST_HTAR = CNT_W'(1);

   initial begin
      assert (DATA_W % 4 == 0) else $fatal(1, "data width must be whole nibbles");
      assert (DATA_W >= 8)     else $fatal(1, "data width below one byte");
   end

   phase_t            ph;
   logic [CNT_W-1:0]  cnt;
   logic              is_wr;
   logic              space_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              live;

   assign live = en & ~framing;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         is_wr   <= 1'b0;
         space_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else if (!live) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         case (ph)
            PH_IDLE: begin
               if (launch && (lad_i == NIB_MRD || lad_i == NIB_MWR)) begin
                  ph    <= PH_ADDR;
                  cnt   <= '0;
                  is_wr <= (lad_i == NIB_MWR);
               end
            end
            PH_ADDR: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST_ADDR) begin
                  cnt <= '0;
                  if (hit) begin
                     addr_q  <= addr_in;
                     space_q <= space;
                     ph      <= is_wr ? PH_WDATA : PH_HTAR;
                  end else begin
                     ph <= PH_IDLE;
                  end
               end
            end
            PH_WDATA: begin
               wdata_q <= {lad_i, wdata_q[DATA_W-1:4]};
               cnt     <= cnt + 1'b1;
               if (cnt == LAST_DATA) begin
                  cnt <= '0;
                  ph  <= PH_HTAR;
               end
            end
            PH_HTAR: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST_HTAR) begin
                  cnt <= '0;
                  ph  <= PH_SYNC_W;
               end
            end
            PH_SYNC_W: begin
               if (mem_ready_i) begin
                  ph <= PH_SYNC_R;
                  if (!is_wr) rdata_q <= mem_rdata_i;
               end
            end
            PH_SYNC_R: begin
               cnt <= '0;
               ph  <= is_wr ? PH_TDRV : PH_RDATA;
            end
            PH_RDATA: begin
               rdata_q <= rdata_q >> 4;
               cnt     <= cnt + 1'b1;
               if (cnt == LAST_DATA) begin
                  cnt <= '0;
                  ph  <= PH_TDRV;
               end
            end
            PH_TDRV: ph <= PH_TREL;
            PH_TREL: ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      lad_oe_o = 1'b0;
      lad_o    = NIB_TAR;
      case (ph)
         PH_SYNC_W: begin lad_oe_o = 1'b1; lad_o = NIB_WAIT;     end
         PH_SYNC_R: begin lad_oe_o = 1'b1; lad_o = NIB_RDY;      end
         PH_RDATA:  begin lad_oe_o = 1'b1; lad_o = rdata_q[3:0]; end
         PH_TDRV:   begin lad_oe_o = 1'b1; lad_o = NIB_TAR;      end
         default:   begin lad_oe_o = 1'b0; lad_o = NIB_TAR;      end
      endcase
   end

   assign addr_shift  = live & (ph == PH_ADDR);
   assign mem_req_o   = (ph == PH_SYNC_W);
   assign mem_we_o    = is_wr;
   assign mem_space_o = space_q;
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;

   // R11: abort releases the bus and drops the request
   a_r11_abort_release : assert property (@(posedge clk) disable iff (!rst_n)
      framing |=> !lad_oe_o && !mem_req_o);

   // R8: a pending request holds its fields until ready
   a_r8_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i && live) |=>
         mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

   // R8: ready is answered with the ready nibble and the request drops
   a_r8_ready_nibble : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ready_i && live) |=>
         lad_oe_o && (lad_o == NIB_RDY) && !mem_req_o);

   // R10: after the turnaround nibble the bus is released
   a_r10_tar_release : assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_TDRV) |=> !lad_oe_o);

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
   import lpc_tgt_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int ID_W     = 4,
   parameter int ID_LSB   = 19,
   parameter bit CHECK_ID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pp_mode_i,
   input  logic              ce_n_i,
   input  logic              frame_n_i,
   input  logic [3:0]        lad_i,
   output logic [3:0]        lad_o,
   output logic              lad_oe_o,
   input  logic [ID_W-1:0]   dev_id_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic              mem_space_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i
);

   logic              en;
   logic              framing;
   logic              launch;
   logic              addr_shift;
   logic              hit;
   logic              space;
   logic [ADDR_W-1:0] addr_dec;

   assign en = ~pp_mode_i;

   lpc_tgt_start u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .frame_n_i (frame_n_i),
      .ce_n_i    (ce_n_i),
      .lad_i     (lad_i),
      .framing_o (framing),
      .launch_o  (launch)
   );

   lpc_tgt_addr #(
      .ADDR_W   (ADDR_W),
      .ID_W     (ID_W),
      .ID_LSB   (ID_LSB),
      .CHECK_ID (CHECK_ID)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (addr_shift),
      .lad_i    (lad_i),
      .dev_id_i (dev_id_i),
      .addr_o   (addr_dec),
      .space_o  (space),
      .hit_o    (hit)
   );

   lpc_tgt_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .framing     (framing),
      .launch      (launch),
      .lad_i       (lad_i),
      .hit         (hit),
      .space       (space),
      .addr_in     (addr_dec),
      .mem_ready_i (mem_ready_i),
      .mem_rdata_i (mem_rdata_i),
      .addr_shift  (addr_shift),
      .lad_o       (lad_o),
      .lad_oe_o    (lad_oe_o),
      .mem_req_o   (mem_req_o),
      .mem_we_o    (mem_we_o),
      .mem_space_o (mem_space_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o)
   );

   // R12: programming mode keeps the bus and storage port quiet
   a_r12_pp_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      pp_mode_i |=> !lad_oe_o && !mem_req_o);

endmodule

// File: tb/lpc_mem_target_tb.sv
`timescale 1ns/1ps
module lpc_mem_target_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pp_mode = 1'b0;
   logic        ce_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad_in = 4'hF;
   logic [3:0]  lad_out;
   logic        lad_oe;
   logic [3:0]  dev_id = 4'b0101;
   logic        mem_req;
   logic        mem_we;
   logic        mem_space;
   logic [18:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        mem_ready = 1'b0;

   int nchecks = 0;
   int nfails  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

   lpc_mem_target u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pp_mode_i   (pp_mode),
      .ce_n_i      (ce_n),
      .frame_n_i   (frame_n),
      .lad_i       (lad_in),
      .lad_o       (lad_out),
      .lad_oe_o    (lad_oe),
      .dev_id_i    (dev_id),
      .mem_req_o   (mem_req),
      .mem_we_o    (mem_we),
      .mem_space_o (mem_space),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .mem_rdata_i (mem_rdata),
      .mem_ready_i (mem_ready)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchecks++;
      if (act !== exp) begin
         nfails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic logic [31:0] mk_addr(input logic [7:0] top, input logic sp,
                                           input logic [3:0] id, input logic [18:0] off);
      return {top, sp, id, off};
   endfunction

   task automatic start_seq(input logic [3:0] n0, input logic [3:0] n1, input logic [3:0] n2, input int cnt);
      frame_n = 1'b0; lad_in = n0; step();
      if (cnt > 1) begin lad_in = n1; step(); end
      if (cnt > 2) begin lad_in = n2; step(); end
   endtask

   task automatic hdr_addr(input logic [3:0] typ, input logic [31:0] a);
      frame_n = 1'b1; lad_in = typ; step();
      for (int i = 7; i >= 0; i--) begin
         lad_in = a[i*4 +: 4];
         step();
      end
   endtask

   task automatic expect_quiet(input int n, input string req);
      lad_in = 4'hF;
      for (int i = 0; i < n; i++) begin
         chk(req, "bus driven", {31'd0, lad_oe}, 32'd0);
         chk(req, "request", {31'd0, mem_req}, 32'd0);
         step();
      end
   endtask

   task automatic sync_phase(input bit we, input logic [18:0] ea, input bit es,
                             input logic [7:0] wd, input int waits);
      int nwait = 0;
      for (int i = 0; i < 40; i++) begin
         if (!mem_req) break;
         if (nwait == 0) begin
            chk("R6", "write enable", {31'd0, mem_we}, {31'd0, we});
            chk("R4", "storage address", {13'd0, mem_addr}, {13'd0, ea});
            chk("R4", "space flag", {31'd0, mem_space}, {31'd0, es});
            if (we) chk("R6", "write byte", {24'd0, mem_wdata}, {24'd0, wd});
         end
         nwait++;
         chk("R8", "wait nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'b0101});
         mem_ready = (nwait > waits);
         step();
      end
      mem_ready = 1'b0;
      chk("R8", "wait clocks", nwait, waits + 1);
      chk("R8", "ready nibble", {26'd0, mem_req, lad_oe, lad_out}, {26'd0, 1'b0, 1'b1, 4'b0000});
   endtask

   task automatic finish_read(input int waits, input logic [18:0] ea, input bit es);
      logic [7:0] exp = ea[7:0] ^ 8'hA5;
      chk("R7", "host tar 1", {31'd0, lad_oe}, 32'd0);
      lad_in = 4'hF; step();
      chk("R7", "host tar 2", {31'd0, lad_oe}, 32'd0);
      step();
      chk("R7", "request raised", {31'd0, mem_req}, 32'd1);
      sync_phase(1'b0, ea, es, 8'h00, waits);
      step();
      chk("R9", "low data nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, exp[3:0]});
      step();
      chk("R9", "high data nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, exp[7:4]});
      step();
      chk("R10", "tar nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'hF});
      step();
      chk("R10", "bus released", {31'd0, lad_oe}, 32'd0);
      step();
   endtask

   task automatic finish_write(input logic [7:0] wd, input int waits, input logic [18:0] ea, input bit es);
      chk("R6", "data phase undriven", {31'd0, lad_oe}, 32'd0);
      lad_in = wd[3:0]; step();
      lad_in = wd[7:4]; step();
      chk("R6", "host tar 1", {31'd0, lad_oe}, 32'd0);
      lad_in = 4'hF; step();
      chk("R6", "host tar 2", {31'd0, lad_oe}, 32'd0);
      step();
      sync_phase(1'b1, ea, es, wd, waits);
      step();
      chk("R10", "tar nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'hF});
      step();
      chk("R10", "bus released", {31'd0, lad_oe}, 32'd0);
      step();
   endtask

   task automatic t_reset();
      chk("R12", "reset bus", {31'd0, lad_oe}, 32'd0);
      chk("R12", "reset request", {31'd0, mem_req}, 32'd0);
   endtask

   task automatic t_read_mem();
      logic [31:0] a = mk_addr(8'hFF, 1'b1, 4'b0101, 19'h41234);
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0100, a);
      finish_read(0, 19'h41234, 1'b1);
   endtask

   task automatic t_write_reg();
      logic [31:0] a = mk_addr(8'h00, 1'b0, 4'b0101, 19'h0ABCD);
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0110, a);
      finish_write(8'h3C, 3, 19'h0ABCD, 1'b0);
   endtask

   task automatic t_held_start();
      logic [31:0] a = mk_addr(8'hFF, 1'b1, 4'b0101, 19'h00077);
      start_seq(4'h5, 4'h3, 4'h0, 3);
      hdr_addr(4'b0100, a);
      finish_read(1, 19'h00077, 1'b1);
      start_seq(4'h0, 4'h0, 4'h2, 3);
      hdr_addr(4'b0100, a);
      expect_quiet(10, "R1");
   endtask

   task automatic t_chip_enable();
      logic [31:0] a = mk_addr(8'hFF, 1'b1, 4'b0101, 19'h00010);
      ce_n = 1'b1; step();
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0100, a);
      expect_quiet(10, "R2");
      ce_n = 1'b1; step();
      frame_n = 1'b0; ce_n = 1'b0; lad_in = 4'h0; step();
      hdr_addr(4'b0100, a);
      expect_quiet(10, "R2");
   endtask

   task automatic t_bad_type();
      logic [31:0] a = mk_addr(8'hFF, 1'b1, 4'b0101, 19'h00010);
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0010, a);
      expect_quiet(10, "R3");
   endtask

   task automatic t_decode_miss();
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0100, mk_addr(8'h7F, 1'b1, 4'b0101, 19'h00010));
      expect_quiet(10, "R5");
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0110, mk_addr(8'hFF, 1'b1, 4'b0011, 19'h00010));
      expect_quiet(14, "R5");
   endtask

   task automatic t_abort_at_ready();
      logic [31:0] a = mk_addr(8'hFF, 1'b1, 4'b0101, 19'h000F0);
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0100, a);
      lad_in = 4'hF; step(); step();
      chk("R11", "request before abort", {31'd0, mem_req}, 32'd1);
      mem_ready = 1'b1; frame_n = 1'b0; lad_in = 4'h0; step();
      mem_ready = 1'b0;
      chk("R11", "abort released bus", {31'd0, lad_oe}, 32'd0);
      chk("R11", "abort dropped request", {31'd0, mem_req}, 32'd0);
      hdr_addr(4'b0100, mk_addr(8'h00, 1'b1, 4'b0101, 19'h00033));
      finish_read(0, 19'h00033, 1'b1);
   endtask

   task automatic t_abort_in_write();
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0110, mk_addr(8'hFF, 1'b1, 4'b0101, 19'h00100));
      lad_in = 4'h1; step();
      frame_n = 1'b0; lad_in = 4'h0; step();
      chk("R11", "abort in data phase", {31'd0, lad_oe}, 32'd0);
      hdr_addr(4'b0110, mk_addr(8'hFF, 1'b1, 4'b0101, 19'h00200));
      finish_write(8'hE7, 0, 19'h00200, 1'b1);
   endtask

   task automatic t_pp_mode();
      pp_mode = 1'b1; step();
      start_seq(4'h0, 4'h0, 4'h0, 1);
      hdr_addr(4'b0100, mk_addr(8'hFF, 1'b1, 4'b0101, 19'h00010));
      expect_quiet(10, "R12");
      pp_mode = 1'b0; step();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      nchecks++;
      nfails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step(); step();
      t_reset();
      t_read_mem();
      t_write_reg();
      t_held_start();
      t_chip_enable();
      t_bad_type();
      t_decode_miss();
      t_abort_at_ready();
      t_abort_in_write();
      t_pp_mode();
      t_read_mem();
      summary();
   end

endmodule